// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block decides, for one eight-input interrupt controller, which pending input should interrupt the processor next and which in-service input a non-specific end-of-interrupt command should retire. The controller's registers are held outside the block. It receives the request, in-service and mask vectors, the index of the input that currently holds the lowest priority, and two mode flags. Bit i of every vector belongs to input i.

Priority is circular. The input just after the lowest-priority one ranks highest, and the ranking wraps modulo eight. Setting the lowest-priority index to 7 gives the usual fixed order, in which input 0 ranks highest. The nested-cascade flag stops the in-service bit of the cascade input from blocking requests. The special-mask flag lets in-service bits block nothing, and it hides masked in-service inputs from end-of-interrupt selection.

Both answers are produced together, combinationally, from the same state. Each answer has a valid flag and an input index.

Top module: `irq_prio_resolver`

## Requirements
- R1: Inputs are ranked starting at (lowest_pin + 1) mod 8 and continuing upward modulo 8, so the input whose index equals lowest_pin ranks last.
- R2: With lowest_pin = 7 the ranking is fixed: input 0 ranks highest and input 7 ranks lowest.
- R3: An input can be reported as pending only if its bit in in_req is 1 and its bit in in_mask is 0.
- R4: While nested_cascade_en is 1, the in_isr bit of input 2 does not block any request.
- R5: While special_mask_en is 0, scanning proceeds from the highest rank downward. If the scan meets an input whose in-service bit blocks, at that input or before any eligible request, pend_valid is 0. This applies even when that same input is also requesting.
- R6: When no input qualifies, the matching valid output is 0 and the matching pin output is 0.
- R7: svc_pin is the highest-ranked input whose in_isr bit is 1. The mode flags change this only as stated in R9.
- R8: While special_mask_en is 1, in_isr has no effect on pend_valid or pend_pin.
- R9: While special_mask_en is 1, an in-service input whose in_mask bit is 1 is skipped in the end-of-interrupt search.
- R10: All outputs follow the inputs with no clocked latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_req | input | 8 | Request vector, bit i = input i |
| in_isr | input | 8 | In-service vector, bit i = input i |
| in_mask | input | 8 | Mask vector, 1 = input disabled |
| lowest_pin | input | 3 | Index of the input with the lowest priority |
| special_mask_en | input | 1 | Special-mask mode flag |
| nested_cascade_en | input | 1 | Nested-cascade mode flag (cascade input 2) |
| pend_valid | output | 1 | A pending input may interrupt |
| pend_pin | output | 3 | Highest-ranked pending input, 0 when none |
| svc_valid | output | 1 | An in-service input is selectable for EOI |
| svc_pin | output | 3 | Input a non-specific EOI clears, 0 when none |

## Verification
The pending search and the end-of-interrupt search are evaluated from the same state, so both answers appear in the same cycle. The two answers interact when an in-service input both blocks a request and is the one end-of-interrupt would retire. Vectors provoke this by placing an in-service bit above, at, or below a request under each mode flag. Each vector is judged on all four outputs at once.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    // Selects the behaviour of a priority scanner instance.
    typedef enum logic [0:0] {
        SCAN_PENDING = 1'b0,   // stops at the first blocking bit
        SCAN_SERVICE = 1'b1    // plain first-hit search
    } scan_kind_e;

    localparam int unsigned IRQ_PINS_DEFAULT    = 8;
    localparam int unsigned CASCADE_PIN_DEFAULT = 2;

endpackage

// File: rtl/irq_prio_rotate.sv
module irq_prio_rotate #(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned PIN_W    = $clog2(NUM_PINS)
) (
    input  logic [NUM_PINS-1:0] vec_in,
    input  logic [PIN_W-1:0]    start_pin,
    output logic [NUM_PINS-1:0] vec_rot
);

    // Position k of the output carries the input that ranks k-th.
    for (genvar k = 0; k < NUM_PINS; k++) begin : g_lane
        logic [PIN_W-1:0] src_idx;
        assign src_idx    = start_pin + PIN_W'(k);
        assign vec_rot[k] = vec_in[src_idx];
    end

endmodule

// File: rtl/irq_prio_first.sv
module irq_prio_first
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_PINS  = 8,
    parameter int unsigned PIN_W     = $clog2(NUM_PINS),
    parameter scan_kind_e  SCAN_KIND = SCAN_SERVICE
) (
    input  logic [NUM_PINS-1:0] hit_rot,
    input  logic [NUM_PINS-1:0] stop_rot,
    output logic                found,
    output logic [PIN_W-1:0]    rank
);

    if (SCAN_KIND == SCAN_PENDING) begin : g_blocking
        // A stop bit ends the search and takes precedence at the same rank.
        always_comb begin
            logic done;
            done  = 1'b0;
            found = 1'b0;
            rank  = '0;
            for (int k = 0; k < NUM_PINS; k++) begin
                if (!done) begin
                    if (stop_rot[k]) begin
                        done = 1'b1;
                    end else if (hit_rot[k]) begin
                        found = 1'b1;
                        rank  = PIN_W'(k);
                        done  = 1'b1;
                    end
                end
            end
        end
    end else begin : g_plain
        logic unused_stop;
        assign unused_stop = ^stop_rot;
        always_comb begin
            found = 1'b0;
            rank  = '0;
            for (int k = NUM_PINS - 1; k >= 0; k--) begin
                if (hit_rot[k]) begin
                    found = 1'b1;
                    rank  = PIN_W'(k);
                end
            end
        end
    end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_PINS    = IRQ_PINS_DEFAULT,
    parameter int unsigned CASCADE_PIN = CASCADE_PIN_DEFAULT
) (
    input  logic [NUM_PINS-1:0]         in_req,
    input  logic [NUM_PINS-1:0]         in_isr,
    input  logic [NUM_PINS-1:0]         in_mask,
    input  logic [$clog2(NUM_PINS)-1:0] lowest_pin,
    input  logic                        special_mask_en,
    input  logic                        nested_cascade_en,
    output logic                        pend_valid,
    output logic [$clog2(NUM_PINS)-1:0] pend_pin,
    output logic                        svc_valid,
    output logic [$clog2(NUM_PINS)-1:0] svc_pin
);

    localparam int unsigned PIN_W = $clog2(NUM_PINS);
    localparam logic [NUM_PINS-1:0] CASCADE_BIT =
        {{(NUM_PINS-1){1'b0}}, 1'b1} << CASCADE_PIN;

    logic [PIN_W-1:0]    start_pin;
    logic [NUM_PINS-1:0] eligible, blocking, svc_cand;
    logic [NUM_PINS-1:0] eligible_rot, blocking_rot, svc_cand_rot;
    logic                pend_found, svc_found;
    logic [PIN_W-1:0]    pend_rank, svc_rank;

    assign start_pin = lowest_pin + PIN_W'(1);

    always_comb begin
        eligible = in_req & ~in_mask;
        if (special_mask_en) begin
            blocking = '0;
            svc_cand = in_isr & ~in_mask;
        end else begin
            blocking = nested_cascade_en ? (in_isr & ~CASCADE_BIT) : in_isr;
            svc_cand = in_isr;
        end
    end

    irq_prio_rotate #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_rot_elig (
        .vec_in(eligible), .start_pin(start_pin), .vec_rot(eligible_rot));
    irq_prio_rotate #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_rot_blk (
        .vec_in(blocking), .start_pin(start_pin), .vec_rot(blocking_rot));
    irq_prio_rotate #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_rot_svc (
        .vec_in(svc_cand), .start_pin(start_pin), .vec_rot(svc_cand_rot));

    irq_prio_first #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W), .SCAN_KIND(SCAN_PENDING)) u_scan_pend (
        .hit_rot(eligible_rot), .stop_rot(blocking_rot),
        .found(pend_found), .rank(pend_rank));
    irq_prio_first #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W), .SCAN_KIND(SCAN_SERVICE)) u_scan_svc (
        .hit_rot(svc_cand_rot), .stop_rot('0),
        .found(svc_found), .rank(svc_rank));

    // Map the winning rank back to an input index; report 0 when none wins.
    always_comb begin
        pend_valid = pend_found;
        svc_valid  = svc_found;
        pend_pin   = pend_found ? PIN_W'(start_pin + pend_rank) : '0;
        svc_pin    = svc_found  ? PIN_W'(start_pin + svc_rank)  : '0;
    end

endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned PIN_W    = $clog2(NUM_PINS)
) (
    input logic [NUM_PINS-1:0] in_req,
    input logic [NUM_PINS-1:0] in_isr,
    input logic [NUM_PINS-1:0] in_mask,
    input logic [PIN_W-1:0]    lowest_pin,
    input logic                special_mask_en,
    input logic                nested_cascade_en,
    input logic                pend_valid,
    input logic [PIN_W-1:0]    pend_pin,
    input logic                svc_valid,
    input logic [PIN_W-1:0]    svc_pin
);

    logic unused_sig;
    assign unused_sig = ^lowest_pin;

    always_comb begin
        // R3: a reported pending input is requested and unmasked
        a_r3_pend_eligible: assert (!pend_valid || (in_req[pend_pin] && !in_mask[pend_pin]));
        // R6: idle results read as zero
        a_r6_pend_idle_zero: assert (pend_valid || pend_pin == '0);
        a_r6_svc_idle_zero: assert (svc_valid || svc_pin == '0);
        // R7: the EOI choice is always an in-service input
        a_r7_svc_in_service: assert (!svc_valid || in_isr[svc_pin]);
        // R8: with special mask on, any eligible request is reported
        a_r8_smm_unblocked: assert (!special_mask_en || ((|(in_req & ~in_mask)) == pend_valid));
        // R9: with special mask on, masked in-service inputs are never chosen
        a_r9_smm_skip_masked: assert (!(special_mask_en && svc_valid) || !in_mask[svc_pin]);
        // R5: in normal mode a reported input is not itself in service
        a_r5_not_self_blocked: assert (!(pend_valid && !special_mask_en && !nested_cascade_en) || !in_isr[pend_pin]);
    end

endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_chk (.*);

// File: tb/irq_prio_resolver_tb_top.sv
module irq_prio_resolver_tb_top;

    typedef struct packed {
        logic [7:0] req;
        logic [7:0] isr;
        logic [7:0] mask;
        logic [2:0] low;
        logic       smm;
        logic       sfn;
        logic       pv;
        logic [2:0] pp;
        logic       sv;
        logic [2:0] sp;
    } vec_t;

    localparam int NVEC = 16;
    // req isr mask low smm sfn | pv pp sv sp
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 8'h00, 8'h00, 3'd7, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0}, // R6 nothing
        '{8'h28, 8'h00, 8'h00, 3'd7, 1'b0, 1'b0, 1'b1, 3'd3, 1'b0, 3'd0}, // R2 fixed order
        '{8'h28, 8'h00, 8'h08, 3'd7, 1'b0, 1'b0, 1'b1, 3'd5, 1'b0, 3'd0}, // R3 mask
        '{8'h09, 8'h00, 8'h00, 3'd3, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 3'd0}, // R1 rotated
        '{8'h30, 8'h00, 8'h00, 3'd4, 1'b0, 1'b0, 1'b1, 3'd5, 1'b0, 3'd0}, // R1 pin4 last
        '{8'h20, 8'h04, 8'h00, 3'd7, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2}, // R5 blocked
        '{8'h20, 8'h04, 8'h00, 3'd7, 1'b0, 1'b1, 1'b1, 3'd5, 1'b1, 3'd2}, // R4 cascade
        '{8'h02, 8'h04, 8'h00, 3'd7, 1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 3'd2}, // R5 higher wins
        '{8'h04, 8'h04, 8'h00, 3'd7, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2}, // R5 equal
        '{8'h20, 8'h04, 8'h00, 3'd7, 1'b1, 1'b0, 1'b1, 3'd5, 1'b1, 3'd2}, // R8 smm
        '{8'h00, 8'h06, 8'h02, 3'd7, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2}, // R9 skip
        '{8'h00, 8'h06, 8'h02, 3'd7, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd1}, // R7 no skip
        '{8'h80, 8'h03, 8'h00, 3'd1, 1'b0, 1'b0, 1'b1, 3'd7, 1'b1, 3'd0}, // R7 rotated
        '{8'h10, 8'h10, 8'h10, 3'd7, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0}, // R9 all masked
        '{8'h81, 8'h00, 8'h00, 3'd6, 1'b0, 1'b0, 1'b1, 3'd7, 1'b0, 3'd0}, // R1 wrap
        '{8'h01, 8'h04, 8'h00, 3'd1, 1'b0, 1'b1, 1'b1, 3'd0, 1'b1, 3'd2}  // R4 rotated
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_req = '0, in_isr = '0, in_mask = '0;
    logic [2:0] lowest_pin = 3'd7;
    logic       special_mask_en = 1'b0, nested_cascade_en = 1'b0;
    logic       pend_valid, svc_valid;
    logic [2:0] pend_pin, svc_pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_prio_resolver dut_i (
        .in_req(in_req), .in_isr(in_isr), .in_mask(in_mask),
        .lowest_pin(lowest_pin), .special_mask_en(special_mask_en),
        .nested_cascade_en(nested_cascade_en),
        .pend_valid(pend_valid), .pend_pin(pend_pin),
        .svc_valid(svc_valid), .svc_pin(svc_pin)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        in_req = v.req; in_isr = v.isr; in_mask = v.mask;
        lowest_pin = v.low; special_mask_en = v.smm; nested_cascade_en = v.sfn;
        #1;
    endtask

    initial begin
        // R6 reset state: no request, no service
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 reset pend_valid", {7'd0, pend_valid}, 8'd0);
        check("R6 reset svc_valid", {7'd0, svc_valid}, 8'd0);
        check("R6 reset pend_pin", {5'd0, pend_pin}, 8'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i]);
            check($sformatf("vec%0d pend_valid", i), {7'd0, pend_valid}, {7'd0, VECS[i].pv});
            check($sformatf("vec%0d pend_pin", i), {5'd0, pend_pin}, {5'd0, VECS[i].pp});
            check($sformatf("vec%0d svc_valid", i), {7'd0, svc_valid}, {7'd0, VECS[i].sv});
            check($sformatf("vec%0d svc_pin", i), {5'd0, svc_pin}, {5'd0, VECS[i].sp});
        end

        // R10: outputs respond within the same cycle, before any clock edge
        @(negedge clk);
        in_req = 8'h40; in_isr = 8'h00; in_mask = 8'h00;
        lowest_pin = 3'd7; special_mask_en = 1'b0; nested_cascade_en = 1'b0;
        #1;
        check("R10 same-cycle pend_pin", {5'd0, pend_pin}, 8'd6);
        in_req = 8'h48;
        #0.5;
        check("R10 same-cycle update", {5'd0, pend_pin}, 8'd3);

        // R1: each choice of lowest_pin makes the next input rank first
        for (int lp = 0; lp < 8; lp++) begin
            @(negedge clk);
            in_req = 8'hFF; in_isr = 8'h00; in_mask = 8'h00;
            lowest_pin = 3'(lp);
            #1;
            check($sformatf("R1 start lp=%0d", lp), {5'd0, pend_pin}, 8'((lp + 1) % 8));
        end

        // R8: in-service bits above a request change nothing in special mask mode
        @(negedge clk);
        in_req = 8'h80; in_isr = 8'h7F; in_mask = 8'h00;
        lowest_pin = 3'd7; special_mask_en = 1'b1; nested_cascade_en = 1'b0;
        #1;
        check("R8 smm ignores isr", {4'd0, pend_valid, pend_pin}, 8'h0F);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule